// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM Core

This block is a synthesizable model of a flow-through synchronous burst SRAM. It stores words of four byte lanes. Each rising clock edge samples the control pins and classifies the cycle as one of four kinds: deselect, begin burst, continue burst or suspend burst. A begin cycle takes the address from the address pins. A continue cycle steps a two-bit burst counter. A suspend cycle accesses the same location again, so it acts as a wait state. A deselect cycle performs no access.

There are two address strobes:
- The processor-side strobe always starts a read.
- The controller-side strobe starts a read or a write, chosen by the write controls.

Three chip enables qualify either strobe. A sleep input forces a powered-down state with the outputs released. Read data flows through: the word is available in the cycle that follows the edge that sampled its address, with no extra output stage. The data output drives zero whenever it is not valid, and a separate valid flag marks valid data. The output enable and the sleep input act on the output without waiting for a clock edge.

Top module: `sbsram_core`

## Requirements
- R1: After the synchronous reset, `rvalid` is 0 and `rdata` is 0 until a read cycle occurs. This holds even with `oe_n` low.
- R2: An edge with `proc_strb_n` low and the chip selected (`sel0_n`=0, `sel1`=1, `sel2_n`=0) begins a read at `addr`. No location is written, whatever `glob_we_n`, `byte_we_n` and `lane_we_n` show.
- R3: For a controller-strobe, continue or suspend cycle, the cycle is a write when `glob_we_n`=0, or when `byte_we_n`=0 with at least one bit of `lane_we_n` at 0. Otherwise the cycle is a read.
- R4: On a write with `glob_we_n`=1, bit i of `lane_we_n` (active low) gates byte lane i, which is bits [8i+7:8i]. Lanes whose bit is 1 keep their old contents.
- R5: `glob_we_n`=0 writes all four lanes of `wdata`, sampled at the same edge, whatever `byte_we_n` and `lane_we_n` show.
- R6: When a burst is active, an edge with both strobes high and `adv_n`=0 accesses the next address. The two low address bits increment and wrap within the aligned four-word block (3 becomes 0). The upper bits are kept.
- R7: When a burst is active, an edge with both strobes high and `adv_n`=1 accesses the current address again.
- R8: A strobe edge with any chip enable inactive is a deselect: there is no access and `rvalid` is 0 afterwards. Later edges without a strobe stay deselected and write nothing.
- R9: While `sleep`=1, `rvalid` is 0 at once (no clock edge needed). Edges taken during sleep access nothing and end any burst.
- R10: After a read edge, `rvalid` = NOT `oe_n` until the next edge. `oe_n` acts without a clock edge. While `rvalid`=1, `rdata` shows the addressed word; while `rvalid`=0, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | External word address |
| proc_strb_n | input | 1 | Processor-side address strobe, active low, forces a read |
| ctrl_strb_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high suspends the burst |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| byte_we_n | input | 1 | Qualifies `lane_we_n`, active low |
| glob_we_n | input | 1 | Global write of all lanes, active low |
| sel0_n | input | 1 | Chip enable, active low |
| sel1 | input | 1 | Chip enable, active high |
| sel2_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low, acts without a clock edge |
| sleep | input | 1 | Power-down request, active high, acts without a clock edge |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data; 0 when not valid |
| rvalid | output | 1 | Read data valid |

## Verification
The hardest situations to reach from the ports are a burst that wraps inside its four-word block, and a burst that is deselected and must stay inert while write controls keep pulsing. Either one needs a chain of edges whose strobes, chip enables and advance inputs line up in a set order. Directed sequences force these chains: a begin at an address ending in 3 followed by continue and suspend edges, and a strobe with one chip enable off followed by continue edges that carry global writes. Constrained random cycles then mix strobes, bursts, writes, sleep and chip-enable faults against a bench reference model, over a memory first loaded with a known pattern.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  // Kind of access decided at a clock edge
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_BEGIN = 2'd1,
    CYC_CONT  = 2'd2,
    CYC_HOLD  = 2'd3
  } cyc_e;
endpackage

// File: rtl/sbsram_decode.sv
module sbsram_decode
  import sbsram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             sleep,
  input  logic             proc_strb_n,
  input  logic             ctrl_strb_n,
  input  logic             adv_n,
  input  logic             sel0_n,
  input  logic             sel1,
  input  logic             sel2_n,
  input  logic             burst_on,
  input  logic [LANES-1:0] lane_we_n,
  input  logic             byte_we_n,
  input  logic             glob_we_n,
  output cyc_e             cyc,
  output logic             do_write,
  output logic [LANES-1:0] lane_wen
);
  logic chip_ok;
  logic wr_req;

  always_comb begin
    chip_ok  = !sel0_n && sel1 && !sel2_n;
    wr_req   = !glob_we_n || (!byte_we_n && !(&lane_we_n));
    cyc      = CYC_IDLE;
    do_write = 1'b0;
    if (!sleep) begin
      if (!proc_strb_n) begin
        // processor strobe: always a read
        if (chip_ok) cyc = CYC_BEGIN;
      end else if (!ctrl_strb_n) begin
        if (chip_ok) begin
          cyc      = CYC_BEGIN;
          do_write = wr_req;
        end
      end else if (burst_on) begin
        cyc      = adv_n ? CYC_HOLD : CYC_CONT;
        do_write = wr_req;
      end
    end
    if (!do_write)
      lane_wen = '0;
    else if (!glob_we_n)
      lane_wen = '1;
    else
      lane_wen = ~lane_we_n;
  end
endmodule

// File: rtl/sbsram_burst_addr.sv
module sbsram_burst_addr
  import sbsram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  cyc_e              cyc,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              burst_on
);
  localparam logic [BURST_W-1:0] STEP = BURST_W'(1);

  always_comb begin
    unique case (cyc)
      CYC_BEGIN: acc_addr = ext_addr;
      CYC_CONT:  acc_addr = {cur_addr[ADDR_W-1:BURST_W],
                             cur_addr[BURST_W-1:0] + STEP};
      default:   acc_addr = cur_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      burst_on <= 1'b0;
    end else begin
      burst_on <= (cyc != CYC_IDLE);
      if (cyc != CYC_IDLE) cur_addr <= acc_addr;
    end
  end
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        lane_wen,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];
    logic [LANE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (lane_wen[g]) bank[addr] <= wdata[g*LANE_W +: LANE_W];
      if (rd_en)       q <= bank[addr];
    end
    assign rdata[g*LANE_W +: LANE_W] = q;
  end
endmodule

// File: rtl/sbsram_core.sv
module sbsram_core
  import sbsram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LANES   = 4,
  parameter int LANE_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    proc_strb_n,
  input  logic                    ctrl_strb_n,
  input  logic                    adv_n,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic                    byte_we_n,
  input  logic                    glob_we_n,
  input  logic                    sel0_n,
  input  logic                    sel1,
  input  logic                    sel2_n,
  input  logic                    oe_n,
  input  logic                    sleep,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);
  localparam int DATA_W = LANES * LANE_W;

  cyc_e              cyc;
  logic              do_write;
  logic [LANES-1:0]  lane_wen;
  logic              burst_on;
  logic [ADDR_W-1:0] acc_addr;
  logic [ADDR_W-1:0] cur_addr;
  logic              rd_en;
  logic              rd_live;
  logic [DATA_W-1:0] arr_q;

  sbsram_decode #(.LANES(LANES)) u_dec (
    .sleep(sleep), .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n),
    .adv_n(adv_n), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .burst_on(burst_on), .lane_we_n(lane_we_n), .byte_we_n(byte_we_n),
    .glob_we_n(glob_we_n), .cyc(cyc), .do_write(do_write), .lane_wen(lane_wen)
  );

  sbsram_burst_addr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_addr (
    .clk(clk), .rst(rst), .cyc(cyc), .ext_addr(addr),
    .acc_addr(acc_addr), .cur_addr(cur_addr), .burst_on(burst_on)
  );

  assign rd_en = (cyc != CYC_IDLE) && !do_write;

  sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk(clk), .rd_en(rd_en), .addr(acc_addr), .lane_wen(lane_wen),
    .wdata(wdata), .rdata(arr_q)
  );

  // remembers whether the last edge was a read
  always_ff @(posedge clk) begin
    if (rst) rd_live <= 1'b0;
    else     rd_live <= rd_en;
  end

  // output enable and sleep gate the output without a clock edge
  assign rvalid = rd_live && !oe_n && !sleep;
  assign rdata  = rvalid ? arr_q : '0;
endmodule

// File: rtl/sbsram_chk.sv
module sbsram_chk
  import sbsram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int BURST_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              proc_strb_n,
  input logic              ctrl_strb_n,
  input logic              sel0_n,
  input logic              sel1,
  input logic              sel2_n,
  input logic              oe_n,
  input logic              sleep,
  input logic              rvalid,
  input logic [DATA_W-1:0] rdata,
  input cyc_e              cyc,
  input logic              do_write,
  input logic [ADDR_W-1:0] cur_addr
);
  logic sel_ok;
  assign sel_ok = !sel0_n && sel1 && !sel2_n;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rvalid);

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rvalid |-> rdata == '0);

  // R2
  proc_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !proc_strb_n && sel_ok) |=> (rvalid == (!oe_n && !sleep)));

  // R8
  desel_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleep && (!proc_strb_n || !ctrl_strb_n) && !sel_ok) |=> !rvalid);

  // R9
  sleep_nop_chk: assert property (@(posedge clk) disable iff (rst)
    sleep |-> (!rvalid && cyc == CYC_IDLE));

  // R3
  write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    do_write |=> !rvalid);

  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_CONT) |=>
      (cur_addr[ADDR_W-1:BURST_W] == $past(cur_addr[ADDR_W-1:BURST_W]) &&
       cur_addr[BURST_W-1:0] == $past(cur_addr[BURST_W-1:0]) + BURST_W'(1)));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_HOLD) |=> $stable(cur_addr));
endmodule

bind sbsram_core sbsram_chk #(
  .ADDR_W(ADDR_W), .DATA_W(LANES*LANE_W), .BURST_W(BURST_W)
) u_chk (
  .clk(clk), .rst(rst), .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n),
  .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n), .oe_n(oe_n), .sleep(sleep),
  .rvalid(rvalid), .rdata(rdata), .cyc(cyc), .do_write(do_write),
  .cur_addr(cur_addr)
);

// File: tb/sbsram_core_tb.sv
`timescale 1ns/1ps
module sbsram_core_tb;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr;
  logic          proc_strb_n, ctrl_strb_n, adv_n, byte_we_n, glob_we_n;
  logic [3:0]    lane_we_n;
  logic          sel0_n, sel1, sel2_n, oe_n, sleep;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic          rvalid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference model state
  logic [31:0]   mem_m [DEPTH];
  bit            m_act, m_rd;
  logic [AW-1:0] m_addr;
  logic [31:0]   m_q;

  always #2.5 clk = ~clk;

  sbsram_core #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .proc_strb_n(proc_strb_n),
    .ctrl_strb_n(ctrl_strb_n), .adv_n(adv_n), .lane_we_n(lane_we_n),
    .byte_we_n(byte_we_n), .glob_we_n(glob_we_n), .sel0_n(sel0_n),
    .sel1(sel1), .sel2_n(sel2_n), .oe_n(oe_n), .sleep(sleep),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  function automatic logic [31:0] pat(input logic [AW-1:0] a);
    return {a, ~a, a ^ 8'h5A, a + 8'h11};
  endfunction

  task automatic idle();
    proc_strb_n = 1; ctrl_strb_n = 1; adv_n = 1;
    lane_we_n = 4'hF; byte_we_n = 1; glob_we_n = 1;
    sel0_n = 0; sel1 = 1; sel2_n = 0; oe_n = 0; sleep = 0;
  endtask

  task automatic access_m();
    logic [31:0] msk;
    bit wr;
    wr = !glob_we_n || (!byte_we_n && lane_we_n != 4'hF);
    if (wr) begin
      if (!glob_we_n) msk = 32'hFFFF_FFFF;
      else msk = {{8{!lane_we_n[3]}}, {8{!lane_we_n[2]}},
                  {8{!lane_we_n[1]}}, {8{!lane_we_n[0]}}};
      mem_m[m_addr] = (mem_m[m_addr] & ~msk) | (wdata & msk);
      m_rd = 0;
    end else begin
      m_rd = 1;
      m_q  = mem_m[m_addr];
    end
  endtask

  task automatic model_edge();
    bit ok;
    ok = !sel0_n && sel1 && !sel2_n;
    if (rst) begin
      m_act = 0; m_rd = 0; m_addr = '0;
    end else if (sleep) begin
      m_act = 0; m_rd = 0;
    end else if (!proc_strb_n) begin
      if (ok) begin m_act = 1; m_addr = addr; m_rd = 1; m_q = mem_m[addr]; end
      else begin m_act = 0; m_rd = 0; end
    end else if (!ctrl_strb_n) begin
      if (ok) begin m_act = 1; m_addr = addr; access_m(); end
      else begin m_act = 0; m_rd = 0; end
    end else if (m_act) begin
      if (!adv_n) m_addr = {m_addr[AW-1:2], m_addr[1:0] + 2'd1};
      access_m();
    end else begin
      m_rd = 0;
    end
  endtask

  task automatic check_out(input string tag);
    logic        ev;
    logic [31:0] ed;
    ev = m_rd && !oe_n && !sleep;
    ed = ev ? m_q : 32'h0;
    checks++;
    if (rvalid !== ev || rdata !== ed) begin
      errors++;
      $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
               tag, rvalid, rdata, ev, ed);
    end
  endtask

  task automatic expect32(input string tag, input logic [31:0] got,
                          input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one clock edge: model update, output check, back to the falling edge
  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    #1;
    check_out(tag);
    @(negedge clk);
  endtask

  task automatic rd_begin(input logic [AW-1:0] a, input string tag);
    idle(); proc_strb_n = 0; addr = a;
    step(tag);
    idle();
  endtask

  initial begin
    idle(); rst = 1; addr = '0; wdata = '0;
    m_act = 0; m_rd = 0; m_addr = '0; m_q = '0;
    void'($urandom(32'd20240607));
    repeat (4) @(negedge clk);
    @(posedge clk); model_edge();
    @(negedge clk); rst = 0;
    #1 check_out("R1 after reset");
    step("R1 idle edge");
    expect32("R1 rdata zero", rdata, 32'h0);

    // preload with global writes (R5)
    for (int a = 0; a < DEPTH; a++) begin
      idle(); ctrl_strb_n = 0; glob_we_n = 0; addr = AW'(a); wdata = pat(AW'(a));
      step("R5 preload");
    end
    idle();
    rd_begin(8'h05, "R5 readback");
    expect32("R5 preload data", rdata, pat(8'h05));

    // R10: flow-through, oe_n acts without an edge
    rd_begin(8'h21, "R10 read");
    expect32("R10 data", rdata, pat(8'h21));
    oe_n = 1; #1; check_out("R10 oe high");
    expect32("R10 rvalid off", {31'b0, rvalid}, 32'h0);
    oe_n = 0; #1; check_out("R10 oe low again");
    step("R10 hold");

    // R2: processor strobe ignores write controls
    idle(); proc_strb_n = 0; glob_we_n = 0; byte_we_n = 0; lane_we_n = 4'h0;
    addr = 8'h20; wdata = 32'hFFFF_FFFF;
    step("R2 forced read");
    expect32("R2 old data", rdata, pat(8'h20));
    idle();
    rd_begin(8'h20, "R2 recheck");
    expect32("R2 unchanged", rdata, pat(8'h20));

    // R3: lane enables without byte_we_n are a read
    idle(); ctrl_strb_n = 0; lane_we_n = 4'h0; addr = 8'h30; wdata = 32'h0;
    step("R3 read via ctrl");
    expect32("R3 read data", rdata, pat(8'h30));
    idle(); ctrl_strb_n = 0; byte_we_n = 0; lane_we_n = 4'hF; addr = 8'h31;
    step("R3 no lane is read");
    expect32("R3 no lane data", rdata, pat(8'h31));

    // R4: lanes 1 and 3 written
    idle(); ctrl_strb_n = 0; byte_we_n = 0; lane_we_n = 4'b0101;
    addr = 8'h40; wdata = 32'hDEAD_BEEF;
    step("R4 masked write");
    rd_begin(8'h40, "R4 readback");
    expect32("R4 lane merge", rdata,
             {8'hDE, pat(8'h40)[23:16], 8'hBE, pat(8'h40)[7:0]});

    // R5: global write overrides disabled lanes
    idle(); ctrl_strb_n = 0; glob_we_n = 0; lane_we_n = 4'hF; byte_we_n = 1;
    addr = 8'h50; wdata = 32'h1234_5678;
    step("R5 global write");
    rd_begin(8'h50, "R5 readback2");
    expect32("R5 all lanes", rdata, 32'h1234_5678);

    // R6 / R7: wrap inside block, then suspend
    rd_begin(8'h13, "R6 begin at 3");
    expect32("R6 begin data", rdata, pat(8'h13));
    adv_n = 0; step("R6 wrap");
    expect32("R6 wrapped to 0", rdata, pat(8'h10));
    step("R6 next");
    expect32("R6 step to 1", rdata, pat(8'h11));
    adv_n = 1; step("R7 suspend");
    expect32("R7 same word", rdata, pat(8'h11));
    // write continue in burst
    adv_n = 0; glob_we_n = 0; wdata = 32'hCAFE_0012;
    step("R6 write continue");
    idle();
    rd_begin(8'h12, "R6 write check");
    expect32("R6 continue wrote", rdata, 32'hCAFE_0012);

    // R8: deselect at strobe, later edges inert
    idle(); ctrl_strb_n = 0; sel1 = 0; glob_we_n = 0; addr = 8'h60; wdata = 32'h0BAD_0BAD;
    step("R8 desel strobe");
    idle(); adv_n = 0; glob_we_n = 0; wdata = 32'h0BAD_0BAD;
    step("R8 inert continue");
    adv_n = 1; step("R8 inert suspend");
    expect32("R8 no output", {31'b0, rvalid}, 32'h0);
    idle();
    rd_begin(8'h60, "R8 recheck");
    expect32("R8 memory kept", rdata, pat(8'h60));
    idle(); proc_strb_n = 0; sel2_n = 1; addr = 8'h61;
    step("R8 proc desel");

    // R9: sleep acts at once and blocks access
    rd_begin(8'h70, "R9 read");
    sleep = 1; #1; check_out("R9 sleep async");
    expect32("R9 rvalid off", {31'b0, rvalid}, 32'h0);
    ctrl_strb_n = 0; glob_we_n = 0; addr = 8'h70; wdata = 32'h5555_AAAA;
    step("R9 sleeping write");
    idle(); adv_n = 0; step("R9 burst ended");
    idle();
    rd_begin(8'h70, "R9 recheck");
    expect32("R9 memory kept", rdata, pat(8'h70));

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      idle();
      r = int'($urandom_range(0, 99));
      if (r < 15)      proc_strb_n = 0;
      else if (r < 40) ctrl_strb_n = 0;
      adv_n     = $urandom_range(0, 1) == 0;
      addr      = AW'($urandom());
      wdata     = $urandom();
      r = int'($urandom_range(0, 99));
      if (r < 20)      glob_we_n = 0;
      else if (r < 45) begin byte_we_n = 0; lane_we_n = 4'($urandom()); end
      else if (r < 55) lane_we_n = 4'($urandom());
      if ($urandom_range(0, 19) == 0) sel0_n = 1;
      if ($urandom_range(0, 19) == 0) sel1 = 0;
      if ($urandom_range(0, 19) == 0) sel2_n = 1;
      if ($urandom_range(0, 29) == 0) sleep = 1;
      if ($urandom_range(0, 9) == 0)  oe_n = 1;
      step("R3 R6 R7 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule